// File: doc/BRIEF.md
# Prioritized Interrupt Mask Arbiter

This block collects interrupt requests for a processor core and reduces them to a single pending request. Seven active-low pins supply requests at fixed priority levels 1 to 7, and several on-chip modules each raise a request at a programmable level. The pins are treated as the requests of requester 0, the pin-handling unit. Modules are requesters 1 to NUM_MOD.

A 3-bit priority mask, written through a 16-bit status word, hides every level at or below it. The exception is level 7, which always gets through. The highest surviving level wins. Among requesters at that level, the one with the larger 4-bit arbitration number wins. A requester whose arbitration number is zero is never selected.

The result is registered and presented as a pending flag, a level and a requester ID. It stays up until the core pulses an acknowledge or the request is withdrawn. The level-7 pin is edge-sensitive. Holding it low produces exactly one recognition.

Top module: `irq_mask_arbiter`

## Requirements
- R1: `irq_n_i` bit k carries the request for level k+1, and 0 means active. A pin request passes two synchronizer flops and one output register, so the pending outputs reflect it on the third rising clock edge after it is applied.
- R2: A request whose level is less than or equal to the mask is not recognized. A write (`sr_we_i`) loads the mask from `sr_wdata_i[10:8]` on the next edge. All other bits of the word are ignored, and without a write the mask holds.
- R3: After reset the mask is 7, so requests at levels 1 to 6 produce no pending output.
- R4: A level-7 request, from a pin or from a module, is recognized whatever the mask value.
- R5: The level-7 pin is recognized on its inactive-to-active transition. Once acknowledged it stays unrecognized until the pin is released and asserted again.
- R6: When several recognized requests are present, the pending level is the highest of them and `pend_id_o` names its requester (0 for pins, i for module i).
- R7: Among recognized requesters at the winning level, the larger arbitration number wins. Equal numbers resolve to the lower requester ID.
- R8: A requester whose arbitration number is 0 is never reported as pending. After reset requester 0 holds 15 and every module holds 0. `arb_we_i` writes `arb_wdata_i` into the entry selected by `arb_sel_i`.
- R9: An acknowledge while pending clears `pend_o` on the next edge. A level-sensitive request that is still present is reported again on the edge after that.
- R10: When all recognized requests are withdrawn, `pend_o` falls.
- R11: Module m raises a request with `mod_req_i[m-1]` at level `mod_lvl_i[3*(m-1) +: 3]`. Level 0 means no request. Module requests reach the pending outputs on the first edge after they are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_n_i | input | 7 | Active-low pin requests, bit k = level k+1 |
| mod_req_i | input | NUM_MOD | Module request flags |
| mod_lvl_i | input | 3*NUM_MOD | Module request levels, 3 bits each |
| sr_we_i | input | 1 | Status word write strobe |
| sr_wdata_i | input | 16 | Status word; bits 10:8 are the mask |
| arb_we_i | input | 1 | Arbitration number write strobe |
| arb_sel_i | input | ID_W | Requester whose number is written |
| arb_wdata_i | input | 4 | New arbitration number |
| ack_i | input | 1 | Acknowledge pulse from the core |
| pend_o | output | 1 | Interrupt pending |
| pend_lvl_o | output | 3 | Level of the pending request |
| pend_id_o | output | ID_W | Requester ID of the pending request |

## Verification
The hardest situation to reach is a level-7 pin that is still held low after its acknowledge. The output must stay quiet there, yet it must fire again after a release and a fresh assertion. The stimulus holds the pin low across an acknowledge and watches for several cycles. It then releases the pin long enough for the synchronizer to see the gap and asserts it again.

Tie-breaks come next in difficulty. Modules are programmed to share an arbitration number, and the pin unit is set to zero, so that precedence and exclusion are both visible at the ports.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned LVL_W   = 3;
  localparam int unsigned ARB_W   = 4;
  localparam int unsigned NUM_PIN = 7;
  localparam logic [LVL_W-1:0] LVL_TOP     = 3'd7;
  localparam logic [LVL_W-1:0] MASK_RESET  = 3'd7;
  localparam logic [ARB_W-1:0] ARB_PIN_RST = 4'd15;
  localparam logic [ARB_W-1:0] ARB_MOD_RST = 4'd0;
  localparam int unsigned SR_MASK_LSB = 8;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync
  import irq_arb_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_PIN-1:0] irq_n_i,
  input  logic               top_clr_i,
  output logic [NUM_PIN-1:0] act_o,
  output logic               top_req_o
);
  logic [NUM_PIN-1:0] meta_q, meta_d;
  logic [NUM_PIN-1:0] sync_q, sync_d;
  logic               prev_q, prev_d;
  logic               armed_q, armed_d;
  logic               top_act, top_rise;

  // next state
  always_comb begin
    meta_d   = ~irq_n_i;
    sync_d   = meta_q;
    top_act  = sync_q[NUM_PIN-1];
    top_rise = top_act & ~prev_q;
    prev_d   = top_act;
    armed_d  = (armed_q | top_rise) & top_act & ~top_clr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q  <= '0;
      sync_q  <= '0;
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      meta_q  <= meta_d;
      sync_q  <= sync_d;
      prev_q  <= prev_d;
      armed_q <= armed_d;
    end
  end

  assign act_o     = sync_q;
  assign top_req_o = armed_q | top_rise;

  AST_TOP_CLR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) (top_clr_i && top_act) |=> !top_req_o) else $error("top request survived clear"); // R5
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_REQ = 4,
  parameter int unsigned ID_W    = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sr_we_i,
  input  logic [15:0]              sr_wdata_i,
  input  logic                     arb_we_i,
  input  logic [ID_W-1:0]          arb_sel_i,
  input  logic [ARB_W-1:0]         arb_wdata_i,
  output logic [LVL_W-1:0]         mask_o,
  output logic [NUM_REQ*ARB_W-1:0] arb_o
);
  logic [LVL_W-1:0] mask_q, mask_d;
  logic             unused_sr;

  assign unused_sr = ^{sr_wdata_i[15:SR_MASK_LSB+LVL_W], sr_wdata_i[SR_MASK_LSB-1:0]};

  always_comb begin
    mask_d = mask_q;
    if (sr_we_i) mask_d = sr_wdata_i[SR_MASK_LSB +: LVL_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= MASK_RESET;
    else         mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_arb
    localparam logic [ARB_W-1:0] RST_VAL = (g == 0) ? ARB_PIN_RST : ARB_MOD_RST;
    logic [ARB_W-1:0] arb_q, arb_d;
    logic             hit;

    always_comb begin
      hit   = arb_we_i && (arb_sel_i == ID_W'(g));
      arb_d = hit ? arb_wdata_i : arb_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) arb_q <= RST_VAL;
      else         arb_q <= arb_d;
    end

    assign arb_o[g*ARB_W +: ARB_W] = arb_q;
  end

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !sr_we_i |=> $stable(mask_q)) else $error("mask changed without write"); // R2
endmodule

// File: rtl/irq_winner_sel.sv
module irq_winner_sel
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_REQ = 4,
  parameter int unsigned ID_W    = 2
) (
  input  logic [NUM_REQ*LVL_W-1:0] lvl_i,
  input  logic [NUM_REQ*ARB_W-1:0] arb_i,
  output logic                     win_vld_o,
  output logic [LVL_W-1:0]         win_lvl_o,
  output logic [ARB_W-1:0]         win_arb_o,
  output logic [ID_W-1:0]          win_id_o
);
  localparam int unsigned KEY_W = LVL_W + ARB_W;

  always_comb begin
    logic [KEY_W-1:0] best;
    logic [KEY_W-1:0] key;
    logic             elig;
    best      = '0;
    win_vld_o = 1'b0;
    win_id_o  = '0;
    for (int i = 0; i < int'(NUM_REQ); i++) begin
      key  = {lvl_i[i*LVL_W +: LVL_W], arb_i[i*ARB_W +: ARB_W]};
      elig = (lvl_i[i*LVL_W +: LVL_W] != '0) && (arb_i[i*ARB_W +: ARB_W] != '0);
      // strict compare keeps the lower index on equal keys
      if (elig && (key > best)) begin
        best      = key;
        win_vld_o = 1'b1;
        win_id_o  = ID_W'(i);
      end
    end
    win_lvl_o = best[KEY_W-1 -: LVL_W];
    win_arb_o = best[ARB_W-1:0];
  end
endmodule

// File: rtl/irq_mask_arbiter.sv
module irq_mask_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_MOD = 3,
  localparam int unsigned NUM_REQ = NUM_MOD + 1,
  localparam int unsigned ID_W    = $clog2(NUM_REQ)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_PIN-1:0]       irq_n_i,
  input  logic [NUM_MOD-1:0]       mod_req_i,
  input  logic [NUM_MOD*LVL_W-1:0] mod_lvl_i,
  input  logic                     sr_we_i,
  input  logic [15:0]              sr_wdata_i,
  input  logic                     arb_we_i,
  input  logic [ID_W-1:0]          arb_sel_i,
  input  logic [ARB_W-1:0]         arb_wdata_i,
  input  logic                     ack_i,
  output logic                     pend_o,
  output logic [LVL_W-1:0]         pend_lvl_o,
  output logic [ID_W-1:0]          pend_id_o
);
  logic [NUM_PIN-1:0]       pin_act;
  logic                     top_req;
  logic                     top_clr;
  logic [LVL_W-1:0]         mask;
  logic [NUM_REQ*ARB_W-1:0] arb_vec;
  logic [NUM_REQ*LVL_W-1:0] lvl_vec;
  logic                     win_vld;
  logic [LVL_W-1:0]         win_lvl;
  logic [ARB_W-1:0]         win_arb;
  logic [ID_W-1:0]          win_id;

  logic                     pend_q, pend_d;
  logic [LVL_W-1:0]         lvl_q, lvl_d;
  logic [ID_W-1:0]          id_q, id_d;
  logic                     load_en;

  irq_pin_sync u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irq_n_i   (irq_n_i),
    .top_clr_i (top_clr),
    .act_o     (pin_act),
    .top_req_o (top_req)
  );

  irq_cfg_regs #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sr_we_i     (sr_we_i),
    .sr_wdata_i  (sr_wdata_i),
    .arb_we_i    (arb_we_i),
    .arb_sel_i   (arb_sel_i),
    .arb_wdata_i (arb_wdata_i),
    .mask_o      (mask),
    .arb_o       (arb_vec)
  );

  // effective level of the pin unit (requester 0)
  always_comb begin
    lvl_vec[0 +: LVL_W] = '0;
    for (int k = 1; k < int'(NUM_PIN); k++) begin
      if (pin_act[k-1] && (LVL_W'(k) > mask)) lvl_vec[0 +: LVL_W] = LVL_W'(k);
    end
    if (top_req) lvl_vec[0 +: LVL_W] = LVL_TOP;
  end

  // effective level of each module requester
  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
    logic [LVL_W-1:0] raw;
    logic             rec;
    always_comb begin
      raw = mod_lvl_i[m*LVL_W +: LVL_W];
      rec = mod_req_i[m] && (raw != '0) && ((raw == LVL_TOP) || (raw > mask));
      lvl_vec[(m+1)*LVL_W +: LVL_W] = rec ? raw : '0;
    end
  end

  irq_winner_sel #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_win (
    .lvl_i     (lvl_vec),
    .arb_i     (arb_vec),
    .win_vld_o (win_vld),
    .win_lvl_o (win_lvl),
    .win_arb_o (win_arb),
    .win_id_o  (win_id)
  );

  // pending register next state
  always_comb begin
    top_clr = ack_i && pend_q && (lvl_q == LVL_TOP) && (id_q == '0);
    pend_d  = win_vld && !(ack_i && pend_q);
    load_en = win_vld;
    lvl_d   = load_en ? win_lvl : lvl_q;
    id_d    = load_en ? win_id  : id_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      lvl_q  <= '0;
      id_q   <= '0;
    end else begin
      pend_q <= pend_d;
      lvl_q  <= lvl_d;
      id_q   <= id_d;
    end
  end

  assign pend_o     = pend_q;
  assign pend_lvl_o = lvl_q;
  assign pend_id_o  = id_q;

  AST_PEND_ABOVE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni) pend_q |-> ((lvl_q == LVL_TOP) || (lvl_q > $past(mask)))) else $error("pending level not above mask"); // R2
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni) (pend_q && ack_i) |=> !pend_q) else $error("ack did not clear pending"); // R9
  AST_PEND_LVL_NZ: assert property (@(posedge clk_i) disable iff (!rst_ni) pend_q |-> (lvl_q != '0)) else $error("pending with level zero"); // R6
  AST_WIN_ARB_NZ: assert property (@(posedge clk_i) disable iff (!rst_ni) win_vld |-> (win_arb != '0)) else $error("winner has arbitration number zero"); // R8
endmodule

// File: tb/irq_mask_arbiter_bench.sv
module irq_mask_arbiter_bench;
  localparam int NUM_MOD = 3;
  localparam int ID_W    = 2;

  typedef struct packed {
    logic [6:0] irq_n;
    logic [2:0] req;
    logic [8:0] lvl;
    logic [5:0] exp;
    logic [3:0] rq;
  } vec_t;

  function automatic logic [5:0] mk(input logic p, input logic [2:0] l, input logic [1:0] id);
    return p ? {1'b1, l, id} : 6'd0;
  endfunction

  // mask = 2; arbitration: pins 15, module1 5, module2 9, module3 9
  localparam int NV = 11;
  localparam vec_t TABLE [NV] = '{
    '{7'h7B, 3'b000, 9'o000, {1'b1,3'd3,2'd0}, 4'd1},  // R1 pin level 3
    '{7'h7D, 3'b000, 9'o000, 6'd0,             4'd2},  // R2 level equal to mask
    '{7'h76, 3'b000, 9'o000, {1'b1,3'd4,2'd0}, 4'd6},  // R6 levels 1 and 4
    '{7'h77, 3'b001, 9'o005, {1'b1,3'd5,2'd1}, 4'd6},  // R6 module above pin
    '{7'h77, 3'b001, 9'o004, {1'b1,3'd4,2'd0}, 4'd7},  // R7 pins 15 beat 5
    '{7'h7F, 3'b110, 9'o660, {1'b1,3'd6,2'd2}, 4'd7},  // R7 equal numbers, lower id
    '{7'h7F, 3'b101, 9'o606, {1'b1,3'd6,2'd3}, 4'd7},  // R7 9 beats 5
    '{7'h7F, 3'b100, 9'o200, 6'd0,             4'd2},  // R2 module at mask
    '{7'h7F, 3'b010, 9'o070, {1'b1,3'd7,2'd2}, 4'd4},  // R4 module level 7
    '{7'h7F, 3'b001, 9'o000, 6'd0,             4'd11}, // R11 level zero ignored
    '{7'h7F, 3'b000, 9'o000, 6'd0,             4'd10}  // R10 all withdrawn
  };

  logic              clk, rst_n;
  logic [6:0]        irq_n;
  logic [NUM_MOD-1:0] mod_req;
  logic [3*NUM_MOD-1:0] mod_lvl;
  logic              sr_we;
  logic [15:0]       sr_wdata;
  logic              arb_we;
  logic [ID_W-1:0]   arb_sel;
  logic [3:0]        arb_wdata;
  logic              ack;
  logic              pend;
  logic [2:0]        pend_lvl;
  logic [ID_W-1:0]   pend_id;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  irq_mask_arbiter #(.NUM_MOD(NUM_MOD)) u_irq_mask_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .irq_n_i(irq_n), .mod_req_i(mod_req), .mod_lvl_i(mod_lvl),
    .sr_we_i(sr_we), .sr_wdata_i(sr_wdata), .arb_we_i(arb_we), .arb_sel_i(arb_sel),
    .arb_wdata_i(arb_wdata), .ack_i(ack), .pend_o(pend), .pend_lvl_o(pend_lvl), .pend_id_o(pend_id)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [5:0] obs();
    return mk(pend, pend_lvl, pend_id);
  endfunction

  task automatic chk(input string rq, input logic [5:0] exp);
    n_cmp++;
    if (obs() !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", rq, obs(), exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_sr(input logic [15:0] v);
    @(negedge clk); sr_we = 1'b1; sr_wdata = v;
    @(negedge clk); sr_we = 1'b0;
  endtask

  task automatic wr_arb(input logic [1:0] s, input logic [3:0] v);
    @(negedge clk); arb_we = 1'b1; arb_sel = s; arb_wdata = v;
    @(negedge clk); arb_we = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; irq_n = 7'h7F; mod_req = '0; mod_lvl = '0;
    sr_we = 1'b0; sr_wdata = '0; arb_we = 1'b0; arb_sel = '0; arb_wdata = '0; ack = 1'b0;
    settle(3);
    rst_n = 1'b1;
    settle(1);
    chk("R3 reset state", 6'd0);

    // R3: mask 7 after reset blocks level 6
    irq_n = 7'h5F; settle(4);
    chk("R3 level 6 blocked", 6'd0);
    irq_n = 7'h7F;
    // R8: module number 0 after reset, even at level 7
    mod_req = 3'b001; mod_lvl = 9'o007; settle(3);
    chk("R8 zero arbitration", 6'd0);
    mod_req = '0; mod_lvl = '0;

    // R4 / R5: level-7 pin held across ack
    irq_n = 7'h3F; settle(4);
    chk("R4 pin level 7", mk(1'b1, 3'd7, 2'd0));
    pulse_ack();
    chk("R9 ack clears", 6'd0);
    settle(5);
    chk("R5 held level 7 once", 6'd0);
    irq_n = 7'h7F; settle(4);
    irq_n = 7'h3F; settle(4);
    chk("R5 re-assert recognized", mk(1'b1, 3'd7, 2'd0));
    pulse_ack();
    irq_n = 7'h7F; settle(4);

    // configuration for the table
    wr_sr(16'h0200);
    wr_arb(2'd1, 4'd5);
    wr_arb(2'd2, 4'd9);
    wr_arb(2'd3, 4'd9);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      irq_n = TABLE[i].irq_n; mod_req = TABLE[i].req; mod_lvl = TABLE[i].lvl;
      settle(4);
      n_cmp++;
      if (obs() !== TABLE[i].exp) begin
        n_bad++;
        $display("FAIL R%0d row %0d: actual %b expected %b", TABLE[i].rq, i, obs(), TABLE[i].exp);
      end
    end

    // R1: exact latency of a pin request (third edge)
    @(negedge clk); irq_n = 7'h7B;
    settle(2);
    chk("R1 not yet after two edges", 6'd0);
    settle(1);
    chk("R1 on third edge", mk(1'b1, 3'd3, 2'd0));

    // R9: level-sensitive request returns after ack
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk("R9 dropped after ack", 6'd0);
    settle(1);
    chk("R9 level request returns", mk(1'b1, 3'd3, 2'd0));

    // R11: module request latency of one edge
    @(negedge clk); mod_req = 3'b010; mod_lvl = 9'o060;
    settle(1);
    chk("R11 module one edge", mk(1'b1, 3'd6, 2'd2));
    mod_req = '0; mod_lvl = '0;

    // R10: withdrawal drops pending
    irq_n = 7'h7F; settle(4);
    chk("R10 withdrawn", 6'd0);

    // R2: only bits 10:8 of the word form the mask
    wr_sr(16'hF8FF);
    irq_n = 7'h7E; settle(4);
    chk("R2 mask 0 passes level 1", mk(1'b1, 3'd1, 2'd0));
    wr_sr(16'hF9FF);
    settle(2);
    chk("R2 mask 1 blocks level 1", 6'd0);
    irq_n = 7'h7F; settle(4);

    // R8: pin unit programmed to zero is never pending
    wr_arb(2'd0, 4'd0);
    irq_n = 7'h3F; settle(4);
    chk("R8 pins at zero", 6'd0);
    irq_n = 7'h7F; settle(4);

    done = 1;
    finish_run();
  end
endmodule